// File: doc/BRIEF.md
# Protected Clock Control Register Bank

This block stores the settings that steer a chip's system clock: which oscillator feeds the system clock, whether the main oscillator and the slow on-chip oscillator are halted, whether the PLL is stopped, and whether oscillation-stop detection is on. Software reaches it over a single-cycle register bus. Each write takes effect on the next rising clock edge, and reads are combinational from the addressed register.

Two safety layers sit in front of the storage. The first is a key-guarded protect register: its bit 0 must be 1 before any clock setting can change. The second is a set of hardware interlocks that refuse writes which would stop a clock that is still in use. Any refusal sets a sticky error flag. An external fallback event can force the selector to the slow on-chip oscillator at any time, and the protect bit has no effect on it.

Top module: `clk_ctrl_bank`

## Requirements
- R1: The source selector is a 3-bit field at address 1, bits [2:0]. 000b picks the slow on-chip oscillator, 010b picks the main oscillator and 100b picks the PLL. The field is visible on clk_sel_o.
- R2: While bit 0 of the protect register is 0, writes to addresses 1 to 5 leave all stored values unchanged.
- R3: A write of 1 to the main-oscillator stop bit (address 3, bit 0) is refused while the selector is 010b or 100b.
- R4: The PLL stop bit (address 2, bit 0) is 1 when the PLL is halted. A write of 1 to the main-oscillator stop bit is refused while the PLL stop bit is 0.
- R5: Writing 1 to the detection enable (address 5, bit 0) clears the slow-oscillator stop bit (address 4, bit 0) on the same edge. While detection is enabled, a write of 1 to that stop bit is refused.
- R6: A cycle with fallback_evt_i high loads 000b into the selector on that edge. This happens whatever the protect bit holds and wins over a write to the selector in the same cycle.
- R7: A write to the protect register (address 0) changes it only when wdata bits [15:8] equal A5h. The register then takes bits [3:0].
- R8: Reset gives selector 000b, main-oscillator stop 1, PLL stop 1, slow-oscillator stop 0, detection enable 0, protect bits 0 and error flag 0.
- R9: A refused write (R3, R4, R5, R10) is accepted only while unlocked, and it sets the error flag (address 6, bit 0 and wr_err_o). Writing 1 to address 6 clears the flag whatever the protect state. Writing 0 there has no effect.
- R10: A selector write with any value other than 000b, 010b or 100b is refused and leaves the selector unchanged.
- R11: A read returns the addressed register in its low bits with all other bits 0, whatever the protect state. Address 7 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for this cycle |
| addr_i | input | 3 | Register address for the write or the read |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for addr_i |
| fallback_evt_i | input | 1 | Forces the selector to the slow oscillator |
| clk_sel_o | output | 3 | Current source selector |
| main_osc_stop_o | output | 1 | Main oscillator halted |
| loco_stop_o | output | 1 | Slow on-chip oscillator halted |
| pll_off_o | output | 1 | PLL halted |
| osc_det_en_o | output | 1 | Oscillation-stop detection enabled |
| wr_err_o | output | 1 | Sticky refused-write flag |

## Verification
The hardest case to reach is a main-oscillator stop refused only because the PLL is running while the slow oscillator is selected. Reset leaves the PLL halted and the main oscillator stopped, so the stimulus first unlocks the bank, starts the main oscillator while the PLL is selected, moves the selector back, and only then starts the PLL before trying the stop write. Refusals from the PLL-selected and main-selected states are reached in the same way, so each interlock condition is seen alone. The fallback event is applied both in the same cycle as a selector write and after the bank has been locked again.

// File: rtl/clk_ctrl_pkg.sv
package clk_ctrl_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [2:0] {
    SRC_LOCO = 3'b000,
    SRC_MAIN = 3'b010,
    SRC_PLL  = 3'b100
  } clk_src_e;

  localparam logic [ADDR_W-1:0] A_PROT = 3'd0;
  localparam logic [ADDR_W-1:0] A_SRC  = 3'd1;
  localparam logic [ADDR_W-1:0] A_PLL  = 3'd2;
  localparam logic [ADDR_W-1:0] A_MOSC = 3'd3;
  localparam logic [ADDR_W-1:0] A_LOCO = 3'd4;
  localparam logic [ADDR_W-1:0] A_DET  = 3'd5;
  localparam logic [ADDR_W-1:0] A_ERR  = 3'd6;

  typedef struct packed {
    logic [2:0] sel;
    logic       pll_off;
    logic       mosc_stop;
    logic       loco_stop;
    logic       det_en;
  } clk_state_t;

  typedef struct packed {
    logic sel;
    logic pll;
    logic mosc;
    logic loco;
    logic det;
  } wr_grant_t;
endpackage

// File: rtl/clk_ctrl_protect.sv
module clk_ctrl_protect
  import clk_ctrl_pkg::*;
#(
  parameter int          KEY_W  = 8,
  parameter int          PROT_W = 4,
  parameter logic [KEY_W-1:0] KEY = 8'hA5
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [KEY_W-1:0]    key_i,
  input  logic [PROT_W-1:0]   bits_i,
  output logic [PROT_W-1:0]   prot_o
);
  logic load;
  assign load = wr_en_i && (addr_i == A_PROT) && (key_i == KEY);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   prot_o <= '0;
    else if (load) prot_o <= bits_i;
  end

  // R7
  key_guard_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == A_PROT && key_i != KEY) |=> $stable(prot_o));
endmodule

// File: rtl/clk_ctrl_interlock.sv
module clk_ctrl_interlock
  import clk_ctrl_pkg::*;
(
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [2:0]        wbits_i,
  input  logic              unlocked_i,
  input  clk_state_t        state_i,
  output wr_grant_t         grant_o,
  output logic              reject_o
);
  logic hit_src, hit_pll, hit_mosc, hit_loco, hit_det;
  logic sel_ok, mosc_unsafe, loco_unsafe;

  assign hit_src  = wr_en_i && unlocked_i && (addr_i == A_SRC);
  assign hit_pll  = wr_en_i && unlocked_i && (addr_i == A_PLL);
  assign hit_mosc = wr_en_i && unlocked_i && (addr_i == A_MOSC);
  assign hit_loco = wr_en_i && unlocked_i && (addr_i == A_LOCO);
  assign hit_det  = wr_en_i && unlocked_i && (addr_i == A_DET);

  always_comb begin
    unique case (wbits_i)
      SRC_LOCO, SRC_MAIN, SRC_PLL: sel_ok = 1'b1;
      default:                     sel_ok = 1'b0;
    endcase
  end

  // stopping main osc is unsafe while it or the PLL feeds the clock, or PLL runs
  assign mosc_unsafe = wbits_i[0] && ((state_i.sel == SRC_MAIN) ||
                                      (state_i.sel == SRC_PLL)  ||
                                      !state_i.pll_off);
  assign loco_unsafe = wbits_i[0] && state_i.det_en;

  assign grant_o.sel  = hit_src && sel_ok;
  assign grant_o.pll  = hit_pll;
  assign grant_o.mosc = hit_mosc && !mosc_unsafe;
  assign grant_o.loco = hit_loco && !loco_unsafe;
  assign grant_o.det  = hit_det;

  assign reject_o = (hit_src && !sel_ok) ||
                    (hit_mosc && mosc_unsafe) ||
                    (hit_loco && loco_unsafe);
endmodule

// File: rtl/clk_ctrl_regs.sv
module clk_ctrl_regs
  import clk_ctrl_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  wr_grant_t  grant_i,
  input  logic [2:0] wbits_i,
  input  logic       reject_i,
  input  logic       err_clr_i,
  input  logic       fallback_i,
  output clk_state_t state_o,
  output logic       err_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_o.sel       <= SRC_LOCO;
      state_o.pll_off   <= 1'b1;
      state_o.mosc_stop <= 1'b1;
      state_o.loco_stop <= 1'b0;
      state_o.det_en    <= 1'b0;
    end else begin
      if (fallback_i)        state_o.sel <= SRC_LOCO;
      else if (grant_i.sel)  state_o.sel <= wbits_i;
      if (grant_i.pll)       state_o.pll_off   <= wbits_i[0];
      if (grant_i.mosc)      state_o.mosc_stop <= wbits_i[0];
      if (grant_i.det)       state_o.det_en    <= wbits_i[0];
      // enabling detection restarts the slow oscillator
      if (grant_i.det && wbits_i[0]) state_o.loco_stop <= 1'b0;
      else if (grant_i.loco)         state_o.loco_stop <= wbits_i[0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        err_o <= 1'b0;
    else if (reject_i)  err_o <= 1'b1;
    else if (err_clr_i) err_o <= 1'b0;
  end

  // R6
  fallback_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fallback_i |=> (state_o.sel == SRC_LOCO));
  // R5
  loco_held_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o.det_en |-> !state_o.loco_stop);
  // R10
  sel_enc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(state_o.sel) && !state_o.sel[0]);
  // R9
  err_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reject_i |=> err_o);
endmodule

// File: rtl/clk_ctrl_bank.sv
module clk_ctrl_bank
  import clk_ctrl_pkg::*;
#(
  parameter int          DATA_W = 16,
  parameter int          PROT_W = 4,
  parameter logic [7:0]  KEY    = 8'hA5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [2:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              fallback_evt_i,
  output logic [2:0]        clk_sel_o,
  output logic              main_osc_stop_o,
  output logic              loco_stop_o,
  output logic              pll_off_o,
  output logic              osc_det_en_o,
  output logic              wr_err_o
);
  localparam int KEY_W   = 8;
  localparam int KEY_LSB = DATA_W - KEY_W;

  logic [PROT_W-1:0] prot;
  clk_state_t        state;
  wr_grant_t         grant;
  logic              reject, err, err_clr;
  logic              unused_mid;

  assign unused_mid = ^wdata_i[KEY_LSB-1:PROT_W];

  clk_ctrl_protect #(.KEY_W(KEY_W), .PROT_W(PROT_W), .KEY(KEY)) u_protect (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_en_i(wr_en_i),
    .addr_i (addr_i),
    .key_i  (wdata_i[DATA_W-1:KEY_LSB]),
    .bits_i (wdata_i[PROT_W-1:0]),
    .prot_o (prot)
  );

  clk_ctrl_interlock u_interlock (
    .wr_en_i   (wr_en_i),
    .addr_i    (addr_i),
    .wbits_i   (wdata_i[2:0]),
    .unlocked_i(prot[0]),
    .state_i   (state),
    .grant_o   (grant),
    .reject_o  (reject)
  );

  assign err_clr = wr_en_i && (addr_i == A_ERR) && wdata_i[0];

  clk_ctrl_regs u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .grant_i   (grant),
    .wbits_i   (wdata_i[2:0]),
    .reject_i  (reject),
    .err_clr_i (err_clr),
    .fallback_i(fallback_evt_i),
    .state_o   (state),
    .err_o     (err)
  );

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_PROT:  rdata_o[PROT_W-1:0] = prot;
      A_SRC:   rdata_o[2:0]        = state.sel;
      A_PLL:   rdata_o[0]          = state.pll_off;
      A_MOSC:  rdata_o[0]          = state.mosc_stop;
      A_LOCO:  rdata_o[0]          = state.loco_stop;
      A_DET:   rdata_o[0]          = state.det_en;
      A_ERR:   rdata_o[0]          = err;
      default: rdata_o             = '0;
    endcase
  end

  assign clk_sel_o       = state.sel;
  assign main_osc_stop_o = state.mosc_stop;
  assign loco_stop_o     = state.loco_stop;
  assign pll_off_o       = state.pll_off;
  assign osc_det_en_o    = state.det_en;
  assign wr_err_o        = err;

  // R2
  locked_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !prot[0] && !fallback_evt_i && addr_i >= A_SRC && addr_i <= A_DET)
    |=> $stable(state));
  // R3
  mosc_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == A_MOSC && wdata_i[0] &&
     (clk_sel_o == SRC_MAIN || clk_sel_o == SRC_PLL)) |=> $stable(main_osc_stop_o));
  // R4
  mosc_pll_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == A_MOSC && wdata_i[0] && !pll_off_o) |=> $stable(main_osc_stop_o));
endmodule

// File: tb/clk_ctrl_bank_tb.sv
module clk_ctrl_bank_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic        evt = 1'b0;
  logic [15:0] rdata;
  logic [2:0]  sel;
  logic        mstop, lstop, poff, den, err;
  int          n_chk = 0, n_bad = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  clk_ctrl_bank u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .fallback_evt_i(evt),
    .clk_sel_o(sel), .main_osc_stop_o(mstop), .loco_stop_o(lstop),
    .pll_off_o(poff), .osc_det_en_o(den), .wr_err_o(err)
  );

  // {wr addr, wdata, evt, rd addr, expected rdata, expected err}
  localparam int NV = 29;
  localparam logic [39:0] VEC [0:NV-1] = '{
    {3'd1, 16'h0004, 1'b0, 3'd1, 16'h0000, 1'b0}, // 0  R2 locked
    {3'd0, 16'h5A01, 1'b0, 3'd0, 16'h0000, 1'b0}, // 1  R7 bad key
    {3'd0, 16'hA501, 1'b0, 3'd0, 16'h0001, 1'b0}, // 2  R7 unlock
    {3'd1, 16'h0004, 1'b0, 3'd1, 16'h0004, 1'b0}, // 3  R1 pll
    {3'd3, 16'h0000, 1'b0, 3'd3, 16'h0000, 1'b0}, // 4  R3 start main
    {3'd3, 16'h0001, 1'b0, 3'd3, 16'h0000, 1'b1}, // 5  R3 pll sel
    {3'd6, 16'h0000, 1'b0, 3'd6, 16'h0001, 1'b1}, // 6  R9 w0
    {3'd6, 16'h0001, 1'b0, 3'd6, 16'h0000, 1'b0}, // 7  R9 w1c
    {3'd1, 16'h0002, 1'b0, 3'd1, 16'h0002, 1'b0}, // 8  R1 main
    {3'd3, 16'h0001, 1'b0, 3'd3, 16'h0000, 1'b1}, // 9  R3 main sel
    {3'd6, 16'h0001, 1'b0, 3'd6, 16'h0000, 1'b0}, // 10 R9
    {3'd1, 16'h0000, 1'b0, 3'd1, 16'h0000, 1'b0}, // 11 R1 loco
    {3'd2, 16'h0000, 1'b0, 3'd2, 16'h0000, 1'b0}, // 12 R4 pll run
    {3'd3, 16'h0001, 1'b0, 3'd3, 16'h0000, 1'b1}, // 13 R4 refused
    {3'd6, 16'h0001, 1'b0, 3'd6, 16'h0000, 1'b0}, // 14 R9
    {3'd2, 16'h0001, 1'b0, 3'd2, 16'h0001, 1'b0}, // 15 R4 pll stop
    {3'd3, 16'h0001, 1'b0, 3'd3, 16'h0001, 1'b0}, // 16 R4 allowed
    {3'd4, 16'h0001, 1'b0, 3'd4, 16'h0001, 1'b0}, // 17 R5 loco stop
    {3'd5, 16'h0001, 1'b0, 3'd4, 16'h0000, 1'b0}, // 18 R5 det clears
    {3'd4, 16'h0001, 1'b0, 3'd4, 16'h0000, 1'b1}, // 19 R5 refused
    {3'd6, 16'h0001, 1'b0, 3'd6, 16'h0000, 1'b0}, // 20 R9
    {3'd1, 16'h0003, 1'b0, 3'd1, 16'h0000, 1'b1}, // 21 R10 bad code
    {3'd6, 16'h0001, 1'b0, 3'd6, 16'h0000, 1'b0}, // 22 R9
    {3'd1, 16'h0002, 1'b1, 3'd1, 16'h0000, 1'b0}, // 23 R6 beats write
    {3'd1, 16'h0004, 1'b0, 3'd1, 16'h0004, 1'b0}, // 24 R1
    {3'd0, 16'hA500, 1'b0, 3'd0, 16'h0000, 1'b0}, // 25 R7 relock
    {3'd5, 16'h0000, 1'b0, 3'd5, 16'h0001, 1'b0}, // 26 R2 R11 locked read
    {3'd7, 16'h0000, 1'b1, 3'd1, 16'h0000, 1'b0}, // 27 R6 while locked
    {3'd0, 16'hA5FF, 1'b0, 3'd0, 16'h000F, 1'b0}  // 28 R7 R11 width
  };

  function automatic string req_of(int i);
    case (i)
      0, 26:                  return "R2";
      4, 5, 9:                return "R3";
      12, 13, 15, 16:         return "R4";
      17, 18, 19:             return "R5";
      23, 27:                 return "R6";
      1, 2, 25, 28:           return "R7";
      6, 7, 10, 14, 20, 22:   return "R9";
      21:                     return "R10";
      default:                return "R1";
    endcase
  endfunction

  task automatic check(string req, logic [15:0] got, logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic check_reset_state();
    check("R8", {13'd0, sel}, 16'h0000);
    check("R8", {15'd0, mstop}, 16'h0001);
    check("R8", {15'd0, poff}, 16'h0001);
    check("R8", {15'd0, lstop}, 16'h0000);
    check("R8", {15'd0, den}, 16'h0000);
    check("R8", {15'd0, err}, 16'h0000);
    addr = 3'd0; #1;
    check("R8", rdata, 16'h0000);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_reset_state();

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      wr_en = 1'b1;
      addr  = VEC[i][39:37];
      wdata = VEC[i][36:21];
      evt   = VEC[i][20];
      @(negedge clk);
      wr_en = 1'b0;
      evt   = 1'b0;
      addr  = VEC[i][19:17];
      #1;
      check(req_of(i), rdata, VEC[i][16:1]);
      check(req_of(i), {15'd0, err}, {15'd0, VEC[i][0]});
    end

    // port view after the table: selector 000b, detection on, main osc stopped
    check("R1", {13'd0, sel}, 16'h0000);
    check("R5", {15'd0, den}, 16'h0001);
    check("R3", {15'd0, mstop}, 16'h0001);
    // R11: unused address reads zero
    addr = 3'd7; #1;
    check("R11", rdata, 16'h0000);

    // R8: reset in mid-run restores defaults
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_reset_state();

    finish_run();
  end
endmodule